// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block takes one memory request from a group of sixteen lanes and carries it out against an on-chip scratchpad. The scratchpad is split into sixteen banks of 32-bit words, and the banks are modelled inside the block. Each lane may supply an access: a valid flag, a 32-bit word address, a write flag and write data. The low address bits choose the bank. Lanes that land in different banks are served in the same cycle. Lanes that land in the same bank but on different words are spread over successive cycles.

Lanes that ask for the very same word are merged into one bank access, and the word is broadcast to all of them. The request therefore takes as many cycles as the largest number of distinct words asked of any single bank. While it works, the block shows the command it sends to each bank in every cycle. When it finishes, it presents the read data of each lane, a mask of the lanes that were served, and a one-cycle done pulse. A new request is taken through a ready/valid handshake, and only once the previous request is complete.

Top module: `bank_conflict_serializer`

## Requirements
- R1: A word address `a` lives in bank `a mod 16` at row `(a / 16) mod ROWS`. In a cycle that serves bank `b`, `bank_en[b]` is high and the row appears in `bank_row[b*RW +: RW]`.
- R2: When every valid lane targets a different bank (stride 1, any odd stride, any permutation), the request completes in one serve cycle.
- R3: When all lanes ask for the same address, one access is made, every lane receives the word, and the request takes one serve cycle.
- R4: The number of serve cycles equals the largest count of distinct words requested from any one bank. Stride 2 takes 2 cycles, stride 4 takes 4, stride 8 takes 8 and stride 16 takes 16.
- R5: Lanes that request the same word are always served in the same cycle, even when other words of that bank are still waiting.
- R6: In each serve cycle, every bank serves the word of its lowest-numbered lane that is still pending.
- R7: When several lanes write the same word in the same cycle, the data of the highest-numbered of those lanes is stored.
- R8: Every served lane, including a writing lane, receives the value the word held before that cycle's write.
- R9: `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Lane inputs are captured at that edge; later changes to them, and `req_valid` while busy, have no effect. `done` is high for exactly one cycle, and `req_ready` returns in the cycle after it.
- R10: A lane whose valid bit is low is neither read nor written. At `done`, `rsp_mask` equals the captured valid set. A request with no valid lane reaches `done` with no serve cycle.
- R11: After reset, `req_ready` is 1, `done` is 0, `rsp_mask` is 0, no bank is enabled, and every scratchpad word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A lane request is offered |
| req_ready | output | 1 | Block is idle and takes a request |
| lane_valid | input | LANES | Per-lane access enable |
| lane_addr | input | LANES*AW | Per-lane word address, lane i at bits i*AW |
| lane_we | input | LANES | Per-lane write flag |
| lane_wdata | input | LANES*DW | Per-lane write data, lane i at bits i*DW |
| bank_en | output | BANKS | Bank accessed in this cycle |
| bank_we | output | BANKS | Bank written in this cycle |
| bank_row | output | BANKS*RW | Row accessed in each bank, bank b at bits b*RW |
| rsp_data | output | LANES*DW | Per-lane read data, lane i at bits i*DW |
| rsp_mask | output | LANES | Lanes served so far in the current request |
| done | output | 1 | One-cycle pulse when the request is complete |

## Verification
The bench builds the block with its default parameters: sixteen lanes, sixteen banks, sixteen rows and the highest-lane write priority. With these values the whole 256-word scratchpad fits in the low address byte, so a flat reference array models it exactly. Address strides from 0 to 17 then cover every serialization depth from one cycle up to the sixteen-cycle worst case, in which all lanes meet in one bank. After each request is accepted, the bench drives junk writes onto the lane inputs. A request that is captured late or taken while busy then shows up as corrupted data on a later read.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SERVE = 2'd1,
      ST_FIN   = 2'd2
   } sbc_state_e;
endpackage

// File: rtl/sbc_bank_pick.sv
module sbc_bank_pick #(
   parameter int          LANES        = 16,
   parameter int          BW           = 4,
   parameter int          RW           = 4,
   parameter int          DW           = 32,
   parameter int unsigned BANK_ID      = 0,
   parameter bit          HI_LANE_WINS = 1'b1
) (
   input  logic [LANES-1:0]         pending,
   input  logic [LANES*(BW+RW)-1:0] lane_idx,
   input  logic [LANES-1:0]         lane_we,
   input  logic [LANES*DW-1:0]      lane_wdata,
   output logic                     active,
   output logic [RW-1:0]            row,
   output logic [LANES-1:0]         serve,
   output logic                     wr_en,
   output logic [DW-1:0]            wr_data
);
   localparam int IW = BW + RW;
   localparam logic [BW-1:0] BID = BW'(BANK_ID);

   logic [LANES-1:0] hit;

   always_comb begin
      for (int i = 0; i < LANES; i++)
         hit[i] = pending[i] && (lane_idx[i*IW +: BW] == BID);
   end

   // lowest pending lane of this bank picks the row
   always_comb begin
      active = 1'b0;
      row    = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (hit[i]) begin
            active = 1'b1;
            row    = lane_idx[i*IW + BW +: RW];
         end
      end
   end

   // every pending lane on the same word rides along
   always_comb begin
      for (int i = 0; i < LANES; i++)
         serve[i] = hit[i] && (lane_idx[i*IW + BW +: RW] == row);
   end

   generate
      if (HI_LANE_WINS) begin : g_hi_wins
         always_comb begin
            wr_en   = 1'b0;
            wr_data = '0;
            for (int i = 0; i < LANES; i++) begin
               if (serve[i] && lane_we[i]) begin
                  wr_en   = 1'b1;
                  wr_data = lane_wdata[i*DW +: DW];
               end
            end
         end
      end else begin : g_lo_wins
         always_comb begin
            wr_en   = 1'b0;
            wr_data = '0;
            for (int i = LANES - 1; i >= 0; i--) begin
               if (serve[i] && lane_we[i]) begin
                  wr_en   = 1'b1;
                  wr_data = lane_wdata[i*DW +: DW];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sbc_bank_store.sv
module sbc_bank_store #(
   parameter int DW   = 32,
   parameter int ROWS = 16,
   parameter int RW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [RW-1:0] row,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) mem[r] <= '0;
      end else if (wr_en) begin
         mem[row] <= wr_data;
      end
   end

   assign rd_data = mem[row];
endmodule

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer
   import sbc_pkg::*;
#(
   parameter int LANES        = 16,
   parameter int BANKS        = 16,
   parameter int ROWS         = 16,
   parameter int AW           = 32,
   parameter int DW           = 32,
   parameter bit HI_LANE_WINS = 1'b1,
   localparam int BW          = $clog2(BANKS),
   localparam int RW          = $clog2(ROWS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [LANES-1:0]      lane_valid,
   input  logic [LANES*AW-1:0]   lane_addr,
   input  logic [LANES-1:0]      lane_we,
   input  logic [LANES*DW-1:0]   lane_wdata,
   output logic [BANKS-1:0]      bank_en,
   output logic [BANKS-1:0]      bank_we,
   output logic [BANKS*RW-1:0]   bank_row,
   output logic [LANES*DW-1:0]   rsp_data,
   output logic [LANES-1:0]      rsp_mask,
   output logic                  done
);
   localparam int IW = BW + RW;

   generate
      if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
         $error("BANKS must be a power of two of at least 2");
      end
      if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
         $error("ROWS must be a power of two of at least 2");
      end
      if (AW < IW) begin : g_bad_aw
         $error("AW too narrow for BANKS*ROWS words");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
   endgenerate

   sbc_state_e              state;
   logic [LANES-1:0]        pending;
   logic [LANES*IW-1:0]     q_idx;
   logic [LANES-1:0]        q_we;
   logic [LANES*DW-1:0]     q_wdata;
   logic [LANES*IW-1:0]     in_idx;
   logic [LANES-1:0]        served;
   logic [LANES-1:0]        left;
   logic [LANES-1:0]        serve_b [BANKS];
   logic [BANKS*DW-1:0]     bank_rd;
   logic [LANES*DW-1:0]     lane_rd;
   logic                    unused_addr_hi;

   // only the bank and row bits of each address are kept
   always_comb begin
      for (int i = 0; i < LANES; i++)
         in_idx[i*IW +: IW] = lane_addr[i*AW +: IW];
   end
   assign unused_addr_hi = ^lane_addr;

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         logic          wr_en_b;
         logic [DW-1:0] wr_data_b;

         sbc_bank_pick #(
            .LANES        (LANES),
            .BW           (BW),
            .RW           (RW),
            .DW           (DW),
            .BANK_ID      (b),
            .HI_LANE_WINS (HI_LANE_WINS)
         ) i_pick (
            .pending    (pending),
            .lane_idx   (q_idx),
            .lane_we    (q_we),
            .lane_wdata (q_wdata),
            .active     (bank_en[b]),
            .row        (bank_row[b*RW +: RW]),
            .serve      (serve_b[b]),
            .wr_en      (wr_en_b),
            .wr_data    (wr_data_b)
         );

         sbc_bank_store #(
            .DW   (DW),
            .ROWS (ROWS),
            .RW   (RW)
         ) i_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en_b),
            .row     (bank_row[b*RW +: RW]),
            .wr_data (wr_data_b),
            .rd_data (bank_rd[b*DW +: DW])
         );

         assign bank_we[b] = wr_en_b;
      end
   endgenerate

   always_comb begin
      served = '0;
      for (int b = 0; b < BANKS; b++) served = served | serve_b[b];
   end

   assign left = pending & ~served;

   always_comb begin
      for (int i = 0; i < LANES; i++)
         lane_rd[i*DW +: DW] = bank_rd[int'(q_idx[i*IW +: BW])*DW +: DW];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         pending  <= '0;
         q_idx    <= '0;
         q_we     <= '0;
         q_wdata  <= '0;
         rsp_data <= '0;
         rsp_mask <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  q_idx    <= in_idx;
                  q_we     <= lane_we;
                  q_wdata  <= lane_wdata;
                  pending  <= lane_valid;
                  rsp_mask <= '0;
                  rsp_data <= '0;
                  state    <= (lane_valid == '0) ? ST_FIN : ST_SERVE;
               end
            end
            ST_SERVE: begin
               pending  <= left;
               rsp_mask <= rsp_mask | served;
               for (int i = 0; i < LANES; i++) begin
                  if (served[i]) rsp_data[i*DW +: DW] <= lane_rd[i*DW +: DW];
               end
               if (left == '0) state <= ST_FIN;
            end
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign done      = (state == ST_FIN);
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
   parameter int LANES = 16,
   parameter int BANKS = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             done,
   input logic [BANKS-1:0] bank_en,
   input logic [LANES-1:0] rsp_mask
);
   a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_not_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_ready);

   a_r9_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> req_ready);

   a_r1_no_bank_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bank_en == '0));

   a_r10_mask_only_grows: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_ready) |-> (($past(rsp_mask) & ~rsp_mask) == '0));
endmodule

bind bank_conflict_serializer sbc_checker #(
   .LANES (LANES),
   .BANKS (BANKS)
) i_sbc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .done      (done),
   .bank_en   (bank_en),
   .rsp_mask  (rsp_mask)
);

// File: tb/test_bank_conflict_serializer.sv
`timescale 1ns/1ps
module test_bank_conflict_serializer;
   localparam int L  = 16;
   localparam int B  = 16;
   localparam int RW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [L-1:0]    lane_valid = '0;
   logic [L*32-1:0] lane_addr = '0;
   logic [L-1:0]    lane_we = '0;
   logic [L*32-1:0] lane_wdata = '0;
   logic [B-1:0]    bank_en;
   logic [B-1:0]    bank_we;
   logic [B*RW-1:0] bank_row;
   logic [L*32-1:0] rsp_data;
   logic [L-1:0]    rsp_mask;
   logic            done;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [31:0]     model [256];
   logic [B-1:0]    first_en;
   logic [B*RW-1:0] first_row;
   logic [L*32-1:0] got_data;
   logic [L-1:0]    got_mask;
   int              got_cyc;

   localparam int NV = 8;
   // base, stride, expected serve cycles
   localparam int VEC [NV][3] = '{
      '{0, 1, 1}, '{5, 3, 1}, '{0, 2, 2}, '{1, 4, 4},
      '{0, 8, 8}, '{0, 16, 16}, '{7, 0, 1}, '{0, 17, 1}
   };

   always #2 clk = ~clk;

   bank_conflict_serializer i_bank_conflict_serializer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .lane_valid(lane_valid), .lane_addr(lane_addr), .lane_we(lane_we),
      .lane_wdata(lane_wdata), .bank_en(bank_en), .bank_we(bank_we),
      .bank_row(bank_row), .rsp_data(rsp_data), .rsp_mask(rsp_mask), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_lanes();
      lane_valid = '0; lane_addr = '0; lane_we = '0; lane_wdata = '0;
   endtask

   task automatic set_lane(input int i, input logic [31:0] a, input logic w,
                           input logic [31:0] d);
      lane_valid[i] = 1'b1;
      lane_addr[i*32 +: 32] = a;
      lane_we[i] = w;
      lane_wdata[i*32 +: 32] = d;
   endtask

   // called at a negedge with idle design; returns at a negedge after ready is back
   task automatic run_req();
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk(!req_ready, "R9", "ready after accept", req_ready, 0);
      first_en  = bank_en;
      first_row = bank_row;
      // junk on the inputs while busy: must not be captured
      for (int i = 0; i < L; i++) set_lane(i, 32'(i), 1'b1, 32'hDEAD0000 | 32'(i));
      got_cyc = 0;
      while (!done && got_cyc < 100) begin
         got_cyc++;
         @(negedge clk);
      end
      if (!done) chk(1'b0, "R9", "watchdog waiting for done", got_cyc, 0);
      got_data = rsp_data;
      got_mask = rsp_mask;
      chk(!req_ready, "R9", "ready during done", req_ready, 0);
      req_valid = 1'b0;
      clear_lanes();
      @(negedge clk);
      chk(req_ready && !done, "R9", "ready back, done one cycle",
          {req_ready, done}, 2'b10);
   endtask

   task automatic do_req(input string tag, input int expcyc);
      logic [L-1:0]  sv;
      logic [L-1:0]  sw;
      logic [31:0]   sa [L];
      logic [31:0]   sd [L];
      logic [31:0]   exp_rd [L];
      int            bad;
      int            bad_lane;
      sv = lane_valid;
      sw = lane_we;
      for (int i = 0; i < L; i++) begin
         sa[i] = lane_addr[i*32 +: 32];
         sd[i] = lane_wdata[i*32 +: 32];
         exp_rd[i] = model[sa[i][7:0]];
      end
      run_req();
      chk(got_cyc == expcyc, tag, "serve cycles", 64'(got_cyc), 64'(expcyc));
      chk(got_mask == sv, tag, "completion mask", got_mask, sv);
      bad = 0;
      bad_lane = 0;
      for (int i = 0; i < L; i++) begin
         if (sv[i] && got_data[i*32 +: 32] !== exp_rd[i]) begin
            if (bad == 0) bad_lane = i;
            bad++;
         end
      end
      if (sv != '0)
         chk(bad == 0, tag, $sformatf("read data lane %0d", bad_lane),
             got_data[bad_lane*32 +: 32], exp_rd[bad_lane]);
      for (int i = 0; i < L; i++)
         if (sv[i] && sw[i]) model[sa[i][7:0]] = sd[i];
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < 256; a++) model[a] = '0;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(req_ready && !done, "R11", "ready/done in reset", {req_ready, done}, 2'b10);
      chk(rsp_mask == '0 && bank_en == '0, "R11", "mask and bank_en in reset",
          {rsp_mask, bank_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !done && rsp_mask == '0, "R11", "state after reset",
          {req_ready, done, rsp_mask}, {2'b10, 16'h0});
      // R11: scratchpad reads zero
      for (int i = 0; i < L; i++) set_lane(i, 32'(i * 17), 1'b0, 0);
      do_req("R11", 1);

      // fill all 256 words, stride 1 rows at a time (R2)
      for (int r = 0; r < 16; r++) begin
         for (int i = 0; i < L; i++)
            set_lane(i, 32'(r * 16 + i), 1'b1, 32'hA5000000 ^ 32'((r * 16 + i) * 33));
         do_req("R2", 1);
      end

      // table of stride patterns
      for (int v = 0; v < NV; v++) begin
         for (int i = 0; i < L; i++)
            set_lane(i, 32'(VEC[v][0] + i * VEC[v][1]), 1'b0, 0);
         if (VEC[v][1] == 0)      do_req("R3", VEC[v][2]);
         else if (VEC[v][2] == 1) do_req("R2", VEC[v][2]);
         else                     do_req("R4", VEC[v][2]);
      end

      // R1: single lane 3 at address 37 -> bank 5 row 2
      set_lane(3, 37, 1'b0, 0);
      do_req("R1", 1);
      chk(first_en == 16'h0020, "R1", "bank_en", first_en, 16'h0020);
      chk(first_row[5*RW +: RW] == 4'd2, "R1", "bank_row of bank 5",
          first_row[5*RW +: RW], 2);

      // R6: lane0 -> 32 (row 2), lane1 -> 16 (row 1); lane0's word first
      set_lane(0, 32, 1'b0, 0);
      set_lane(1, 16, 1'b0, 0);
      do_req("R6", 2);
      chk(first_row[0 +: RW] == 4'd2, "R6", "first row of bank 0", first_row[0 +: RW], 2);

      // R5: lanes 0-7 same word 0, lanes 8-15 same word 16
      for (int i = 0; i < L; i++) set_lane(i, (i < 8) ? 32'd0 : 32'd16, 1'b0, 0);
      do_req("R5", 2);

      // R7: lanes 2, 5, 9 write word 50 together; lane 9 wins
      set_lane(2, 50, 1'b1, 32'h11111111);
      set_lane(9, 50, 1'b1, 32'h99999999);
      set_lane(5, 50, 1'b1, 32'h55555555);
      do_req("R7", 1);
      set_lane(0, 50, 1'b0, 0);
      do_req("R7", 1);
      chk(got_data[31:0] == 32'h99999999, "R7", "winning write data",
          got_data[31:0], 32'h99999999);

      // R8: lane 0 reads 60 while lane 4 writes it
      set_lane(0, 60, 1'b0, 0);
      set_lane(4, 60, 1'b1, 32'hCAFE0060);
      do_req("R8", 1);
      set_lane(7, 60, 1'b0, 0);
      do_req("R8", 1);
      chk(got_data[7*32 +: 32] == 32'hCAFE0060, "R8", "written value later",
          got_data[7*32 +: 32], 32'hCAFE0060);

      // R10: invalid writing lane ignored
      set_lane(0, 71, 1'b0, 0);
      lane_addr[1*32 +: 32] = 70; lane_we[1] = 1'b1; lane_wdata[1*32 +: 32] = 32'hBAD;
      do_req("R10", 1);
      set_lane(1, 70, 1'b0, 0);
      do_req("R10", 1);
      // R10: empty request
      clear_lanes();
      do_req("R10", 0);
      chk(got_mask == '0, "R10", "empty mask", got_mask, 0);

      // R9: junk driven while busy never landed
      for (int i = 0; i < L; i++) set_lane(i, 32'(i), 1'b0, 0);
      do_req("R9", 1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule